// File: doc/BRIEF.md
# GPIO Bank Control Registers

This block holds the configuration of one bank of eight general-purpose pins. It keeps four registers: a function selector with four bits per pin, a data register with one bit per pin, a pull selector with two bits per pin, and a drive register that carries a two-bit strength per pin in its low half and a one-bit slew choice per pin above it. From these registers it drives the pad output enables, output levels, pull controls and drive controls. The pad inputs pass through a two-stage synchroniser, and the data register reads return those samples.

Software can reach the registers in two ways. A plain word bus writes or reads a whole register. A per-pin command port changes a single pin's field and leaves every other pin alone. The command port checks its argument before it acts. An unknown pull code clears the pin's pull field, which turns the pulls off. An unknown strength or slew code leaves the drive register exactly as it was.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads zero and every pad control output is zero. All pins start as inputs with no pull.
- R2: A bus write with bus_sel=1 and bus_wr=1 replaces a whole register. Word address 0 selects the function selector (32 bits), 1 the data register (8 bits), 2 the pull selector (16 bits) and 3 the drive register (24 bits). A read with bus_sel=1 and bus_wr=0 returns the register on bus_rdata one clock later, and bits above each register's width read as zero.
- R3: Pin p owns function bits [4p+3:4p]. pad_oe[p] is 1 exactly when that field holds 1 (output). Code 0 means input.
- R4: A read of the data register returns the stored data bit for output pins. For every other pin it returns pad_in after a two-flop synchroniser, so the pad value must have been stable for two clocks before the read.
- R5: A command acts on the pin slot given by the low three bits of cmd_pin. Higher pin-number bits are ignored, and the fields of the other seven pins do not change.
- R6: cmd_op 0 writes cmd_arg into the pin's function field. cmd_op 1 writes the input code 0. cmd_op 7 does nothing.
- R7: cmd_op 2 writes the output code 1 into the pin's function field and, in the same cycle, sets the pin's data bit to 1 if cmd_arg is nonzero and to 0 otherwise.
- R8: cmd_op 3 sets the pin's data bit to (cmd_arg != 0) and leaves the function field unchanged.
- R9: cmd_op 4 writes pull code 1 (pull-down) or 3 (pull-up) into pull bits [2p+1:2p]. Any other cmd_arg clears that field to 0 (no pull).
- R10: cmd_op 5 with cmd_arg 0 to 3 writes that strength into drive bits [2p+1:2p]. With cmd_arg of 4 or more, the whole drive register stays unchanged.
- R11: cmd_op 6 with cmd_arg 0 (fast) clears drive bit 16+p, and with cmd_arg 1 (slow) sets it. With cmd_arg of 2 or more, the drive register stays unchanged.
- R12: When a bus write and a command target the same register in the same cycle, the command's field update is applied on top of the written word.
- R13: pad_out mirrors the data register, pad_pull mirrors the pull selector, pad_drive mirrors drive bits [15:0] and pad_slow mirrors drive bits [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| cmd_valid | input | 1 | Per-pin command strobe |
| cmd_op | input | 3 | Command operation code |
| cmd_pin | input | 8 | Pin number; low three bits pick the slot |
| cmd_arg | input | 4 | Command argument (function, level, pull, strength or slew code) |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| pad_pull | output | 16 | Pull selection, two bits per pin |
| pad_drive | output | 16 | Drive strength, two bits per pin |
| pad_slow | output | 8 | Slew selection, one bit per pin |

## Verification
The command port is exercised with every operation code and with arguments drawn from the full four-bit range. Because invalid codes show up often in that range, the random runs distinguish the clear-on-invalid pull rule from the hold-on-invalid drive and slew rules. Pin numbers with random upper bits show whether the slot decode ignores those bits, and a register model confirms that the other pins' fields stay put. Data reads are taken with a random mix of input and output pins against a freshly changed pad pattern, which tells stored data apart from synchronised pad samples. A directed case with a same-cycle bus write and command fixes the merge order.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    OP_FUNC   = 3'd0,
    OP_INPUT  = 3'd1,
    OP_OUTPUT = 3'd2,
    OP_LEVEL  = 3'd3,
    OP_PULL   = 3'd4,
    OP_DRIVE  = 3'd5,
    OP_RATE   = 3'd6,
    OP_NOP    = 3'd7
  } pin_op_e;

  typedef enum logic [1:0] {
    ADDR_FUNC  = 2'd0,
    ADDR_DATA  = 2'd1,
    ADDR_PULL  = 2'd2,
    ADDR_DRIVE = 2'd3
  } reg_addr_e;

  localparam logic [3:0] FN_INPUT  = 4'd0;
  localparam logic [3:0] FN_OUTPUT = 4'd1;

  localparam logic [1:0] PULL_NONE = 2'd0;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd3;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_sync
);

  logic [STAGES-1:0][NPINS-1:0] stg_q;
  logic [STAGES-1:0][NPINS-1:0] stg_d;

  assign stg_d[0] = pad_in;

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    assign stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign pad_sync = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cmd.sv
module gpio_pin_cmd
  import gpio_bank_pkg::*;
#(
  parameter int NPINS      = 8,
  parameter int PIN_NUM_W  = 8,
  parameter int FUNC_W     = 4,
  parameter int PULL_W     = 2,
  parameter int DRV_W      = 2,
  parameter int RATE_OFS   = 16,
  parameter int FUNC_REG_W = NPINS * FUNC_W,
  parameter int PULL_REG_W = NPINS * PULL_W,
  parameter int DRV_REG_W  = RATE_OFS + NPINS
) (
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [PIN_NUM_W-1:0]  cmd_pin,
  input  logic [FUNC_W-1:0]     cmd_arg,
  output logic                  func_hit,
  output logic [FUNC_REG_W-1:0] func_clr,
  output logic [FUNC_REG_W-1:0] func_set,
  output logic                  dat_hit,
  output logic [NPINS-1:0]      dat_clr,
  output logic [NPINS-1:0]      dat_set,
  output logic                  pull_hit,
  output logic [PULL_REG_W-1:0] pull_clr,
  output logic [PULL_REG_W-1:0] pull_set,
  output logic                  drv_hit,
  output logic [DRV_REG_W-1:0]  drv_clr,
  output logic [DRV_REG_W-1:0]  drv_set
);

  localparam int SLOT_W    = $clog2(NPINS);
  localparam int FUNC_ONES = (1 << FUNC_W) - 1;
  localparam int PULL_ONES = (1 << PULL_W) - 1;
  localparam int DRV_ONES  = (1 << DRV_W) - 1;
  localparam int DRV_CODES = 1 << DRV_W;

  logic [SLOT_W-1:0] slot;
  logic              level;
  logic              pull_ok;
  logic              drv_ok;
  logic              rate_ok;
  int                f_sh;
  int                p_sh;
  int                d_sh;
  int                r_sh;

  assign slot    = cmd_pin[SLOT_W-1:0];
  assign level   = |cmd_arg;
  assign pull_ok = (cmd_arg == FUNC_W'(PULL_DOWN)) || (cmd_arg == FUNC_W'(PULL_UP));
  assign drv_ok  = (cmd_arg < FUNC_W'(DRV_CODES));
  assign rate_ok = (cmd_arg < FUNC_W'(2));
  assign f_sh    = int'(slot) * FUNC_W;
  assign p_sh    = int'(slot) * PULL_W;
  assign d_sh    = int'(slot) * DRV_W;
  assign r_sh    = RATE_OFS + int'(slot);

  always_comb begin
    func_hit = 1'b0;
    func_clr = '0;
    func_set = '0;
    dat_hit  = 1'b0;
    dat_clr  = '0;
    dat_set  = '0;
    pull_hit = 1'b0;
    pull_clr = '0;
    pull_set = '0;
    drv_hit  = 1'b0;
    drv_clr  = '0;
    drv_set  = '0;
    if (cmd_valid) begin
      case (pin_op_e'(cmd_op))
        OP_FUNC: begin
          func_hit = 1'b1;
          func_clr = FUNC_REG_W'(FUNC_ONES) << f_sh;
          func_set = FUNC_REG_W'(cmd_arg) << f_sh;
        end
        OP_INPUT: begin
          func_hit = 1'b1;
          func_clr = FUNC_REG_W'(FUNC_ONES) << f_sh;
          func_set = FUNC_REG_W'(FN_INPUT) << f_sh;
        end
        OP_OUTPUT: begin
          func_hit = 1'b1;
          func_clr = FUNC_REG_W'(FUNC_ONES) << f_sh;
          func_set = FUNC_REG_W'(FN_OUTPUT) << f_sh;
          dat_hit  = 1'b1;
          dat_clr  = NPINS'(1) << slot;
          dat_set  = NPINS'(level) << slot;
        end
        OP_LEVEL: begin
          dat_hit = 1'b1;
          dat_clr = NPINS'(1) << slot;
          dat_set = NPINS'(level) << slot;
        end
        OP_PULL: begin
          pull_hit = 1'b1;
          pull_clr = PULL_REG_W'(PULL_ONES) << p_sh;
          if (pull_ok) pull_set = PULL_REG_W'(cmd_arg[PULL_W-1:0]) << p_sh;
        end
        OP_DRIVE: begin
          if (drv_ok) begin
            drv_hit = 1'b1;
            drv_clr = DRV_REG_W'(DRV_ONES) << d_sh;
            drv_set = DRV_REG_W'(cmd_arg[DRV_W-1:0]) << d_sh;
          end
        end
        OP_RATE: begin
          if (rate_ok) begin
            drv_hit = 1'b1;
            drv_clr = DRV_REG_W'(1) << r_sh;
            drv_set = DRV_REG_W'(cmd_arg[0]) << r_sh;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_merge_reg.sv
module gpio_merge_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  input  logic         cmd_hit,
  input  logic [W-1:0] cmd_clr,
  input  logic [W-1:0] cmd_set,
  output logic [W-1:0] q
);

  logic [W-1:0] d;
  logic         en;

  assign en = bus_we | cmd_hit;

  always_comb begin
    d = q;
    if (bus_we)  d = bus_wdata;
    if (cmd_hit) d = (d & ~cmd_clr) | cmd_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int PIN_NUM_W = 8,
  parameter int FUNC_W    = 4,
  parameter int PULL_W    = 2,
  parameter int DRV_W     = 2,
  parameter int RATE_OFS  = 16,
  parameter int BUS_W     = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [1:0]              bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [PIN_NUM_W-1:0]    cmd_pin,
  input  logic [FUNC_W-1:0]       cmd_arg,
  input  logic [NPINS-1:0]        pad_in,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS*PULL_W-1:0] pad_pull,
  output logic [NPINS*DRV_W-1:0]  pad_drive,
  output logic [NPINS-1:0]        pad_slow
);

  localparam int FUNC_REG_W = NPINS * FUNC_W;
  localparam int PULL_REG_W = NPINS * PULL_W;
  localparam int DRV_REG_W  = RATE_OFS + NPINS;
  localparam int STR_W      = NPINS * DRV_W;
  localparam int SLOT_W     = $clog2(NPINS);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // bus write strobes
  logic bus_we;
  logic func_we, dat_we, pull_we, drv_we;

  assign bus_we  = bus_sel & bus_wr;
  assign func_we = bus_we & (reg_addr_e'(bus_addr) == ADDR_FUNC);
  assign dat_we  = bus_we & (reg_addr_e'(bus_addr) == ADDR_DATA);
  assign pull_we = bus_we & (reg_addr_e'(bus_addr) == ADDR_PULL);
  assign drv_we  = bus_we & (reg_addr_e'(bus_addr) == ADDR_DRIVE);

  // per-pin command decode
  logic                  func_hit, dat_hit, pull_hit, drv_hit;
  logic [FUNC_REG_W-1:0] func_clr, func_set, func_q;
  logic [NPINS-1:0]      dat_clr, dat_set, dat_q;
  logic [PULL_REG_W-1:0] pull_clr, pull_set, pull_q;
  logic [DRV_REG_W-1:0]  drv_clr, drv_set, drv_q;

  gpio_pin_cmd #(
    .NPINS(NPINS), .PIN_NUM_W(PIN_NUM_W), .FUNC_W(FUNC_W), .PULL_W(PULL_W),
    .DRV_W(DRV_W), .RATE_OFS(RATE_OFS), .FUNC_REG_W(FUNC_REG_W),
    .PULL_REG_W(PULL_REG_W), .DRV_REG_W(DRV_REG_W)
  ) u_cmd (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin), .cmd_arg(cmd_arg),
    .func_hit(func_hit), .func_clr(func_clr), .func_set(func_set),
    .dat_hit(dat_hit),   .dat_clr(dat_clr),   .dat_set(dat_set),
    .pull_hit(pull_hit), .pull_clr(pull_clr), .pull_set(pull_set),
    .drv_hit(drv_hit),   .drv_clr(drv_clr),   .drv_set(drv_set)
  );

  // registers
  gpio_merge_reg #(.W(FUNC_REG_W)) u_func (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(func_we), .bus_wdata(bus_wdata[FUNC_REG_W-1:0]),
    .cmd_hit(func_hit), .cmd_clr(func_clr), .cmd_set(func_set), .q(func_q));

  gpio_merge_reg #(.W(NPINS)) u_dat (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(dat_we), .bus_wdata(bus_wdata[NPINS-1:0]),
    .cmd_hit(dat_hit), .cmd_clr(dat_clr), .cmd_set(dat_set), .q(dat_q));

  gpio_merge_reg #(.W(PULL_REG_W)) u_pull (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(pull_we), .bus_wdata(bus_wdata[PULL_REG_W-1:0]),
    .cmd_hit(pull_hit), .cmd_clr(pull_clr), .cmd_set(pull_set), .q(pull_q));

  gpio_merge_reg #(.W(DRV_REG_W)) u_drv (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(drv_we), .bus_wdata(bus_wdata[DRV_REG_W-1:0]),
    .cmd_hit(drv_hit), .cmd_clr(drv_clr), .cmd_set(drv_set), .q(drv_q));

  // pad input synchroniser
  logic [NPINS-1:0] pad_sync;

  gpio_pad_sync #(.NPINS(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pad_in(pad_in), .pad_sync(pad_sync));

  // pad controls
  for (genvar p = 0; p < NPINS; p++) begin : g_oe
    assign pad_oe[p] = (func_q[p*FUNC_W +: FUNC_W] == FUNC_W'(FN_OUTPUT));
  end

  assign pad_out   = dat_q;
  assign pad_pull  = pull_q;
  assign pad_drive = drv_q[STR_W-1:0];
  assign pad_slow  = drv_q[RATE_OFS +: NPINS];

  // registered read path
  logic             rd_en;
  logic [BUS_W-1:0] rd_mux;
  logic [NPINS-1:0] dat_view;

  assign rd_en    = bus_sel & ~bus_wr;
  assign dat_view = (dat_q & pad_oe) | (pad_sync & ~pad_oe);

  always_comb begin
    case (reg_addr_e'(bus_addr))
      ADDR_FUNC: rd_mux = BUS_W'(func_q);
      ADDR_DATA: rd_mux = BUS_W'(dat_view);
      ADDR_PULL: rd_mux = BUS_W'(pull_q);
      default:   rd_mux = BUS_W'(drv_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (rd_en)  bus_rdata <= rd_mux;
  end

  // R10
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_DRIVE && cmd_arg >= FUNC_W'(1 << DRV_W) && !drv_we)
    |=> ($stable(pad_drive) && $stable(pad_slow)));

  // R11
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_RATE && cmd_arg >= FUNC_W'(2) && !drv_we)
    |=> ($stable(pad_drive) && $stable(pad_slow)));

  // R9
  pull_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_PULL && cmd_arg != FUNC_W'(PULL_DOWN)
     && cmd_arg != FUNC_W'(PULL_UP) && !pull_we)
    |=> (((pad_pull >> (PULL_W * int'($past(cmd_pin[SLOT_W-1:0]))))
          & PULL_REG_W'((1 << PULL_W) - 1)) == '0));

  // R7
  out_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_OUTPUT && !func_we)
    |=> pad_oe[$past(cmd_pin[SLOT_W-1:0])]);

  // R3
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd_valid && !func_we) |=> $stable(pad_oe));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_pin;
  logic [3:0]  cmd_arg;
  logic [7:0]  pad_in, pad_oe, pad_out, pad_slow;
  logic [15:0] pad_pull, pad_drive;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_func;
  logic [7:0]  m_dat;
  logic [15:0] m_pull;
  logic [23:0] m_drv;
  logic [7:0]  m_pad;

  always #4 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pin(cmd_pin), .cmd_arg(cmd_arg), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pull(pad_pull), .pad_drive(pad_drive), .pad_slow(pad_slow));

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int p = 0; p < 8; p++) r[p] = (m_func[4*p +: 4] == 4'd1);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    logic [7:0] oe;
    oe = exp_oe();
    case (a)
      2'd0:    return m_func;
      2'd1:    return {24'd0, (m_dat & oe) | (m_pad & ~oe)};
      2'd2:    return {16'd0, m_pull};
      default: return {8'd0, m_drv};
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0, 1:    return "R6";
      2:       return "R7";
      3:       return "R8";
      4:       return "R9";
      5:       return "R10";
      6:       return "R11";
      default: return "R5";
    endcase
  endfunction

  function automatic void model_bus(logic [1:0] a, logic [31:0] d);
    case (a)
      2'd0:    m_func = d;
      2'd1:    m_dat  = d[7:0];
      2'd2:    m_pull = d[15:0];
      default: m_drv  = d[23:0];
    endcase
  endfunction

  function automatic void model_cmd(int op, logic [7:0] pin, logic [3:0] arg);
    int s;
    s = int'(pin[2:0]);
    case (op)
      0: m_func[4*s +: 4] = arg;
      1: m_func[4*s +: 4] = 4'd0;
      2: begin m_func[4*s +: 4] = 4'd1; m_dat[s] = (arg != 0); end
      3: m_dat[s] = (arg != 0);
      4: m_pull[2*s +: 2] = (arg == 4'd1 || arg == 4'd3) ? arg[1:0] : 2'd0;
      5: if (arg < 4) m_drv[2*s +: 2] = arg[1:0];
      6: if (arg < 2) m_drv[16+s] = arg[0];
      default: ;
    endcase
  endfunction

  function automatic void check_ports(string tag);
    chk({tag, "/R3 oe"}, {24'd0, pad_oe}, {24'd0, exp_oe()});
    chk({tag, "/R13 out"}, {24'd0, pad_out}, {24'd0, m_dat});
    chk({tag, "/R13 pull"}, {16'd0, pad_pull}, {16'd0, m_pull});
    chk({tag, "/R13 drive"}, {16'd0, pad_drive}, {16'd0, m_drv[15:0]});
    chk({tag, "/R13 slow"}, {24'd0, pad_slow}, {24'd0, m_drv[23:16]});
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_bus(a, d);
    check_ports("R2");
  endtask

  task automatic command(input int op, input logic [7:0] pin, input logic [3:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pin = pin; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, pin, arg);
    check_ports(op_tag(op));
  endtask

  task automatic read_chk(input logic [1:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    m_pad  = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 4; a++) read_chk(2'(a), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    cmd_valid = 1'b0; cmd_op = 3'd7; cmd_pin = '0; cmd_arg = '0; pad_in = '0;
    m_func = '0; m_dat = '0; m_pull = '0; m_drv = '0; m_pad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_ports("R1");
    read_all("R1");

    // R2 whole-register writes, upper bits read zero
    bus_write(2'd0, 32'h0000_0011);
    bus_write(2'd1, 32'hFFFF_FFA5);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_write(2'd3, 32'hFFFF_FFFF);
    read_all("R2");

    // R4 mixed input/output pins against pad pattern
    set_pad(8'h3C);
    read_chk(2'd1, "R4");
    set_pad(8'hC3);
    read_chk(2'd1, "R4");

    // R9 pull codes: invalid clears, valid written
    command(4, 8'd10, 4'd2);  read_chk(2'd2, "R9");
    command(4, 8'd2,  4'd3);  read_chk(2'd2, "R9");
    command(4, 8'd2,  4'd1);  read_chk(2'd2, "R9");
    command(4, 8'd7,  4'd15); read_chk(2'd2, "R9");

    // R10 strength codes
    command(5, 8'd3, 4'd7);   read_chk(2'd3, "R10");
    command(5, 8'd3, 4'd1);   read_chk(2'd3, "R10");

    // R11 slew codes
    command(6, 8'd5, 4'd3);   read_chk(2'd3, "R11");
    command(6, 8'd5, 4'd0);   read_chk(2'd3, "R11");
    command(6, 8'd5, 4'd1);   read_chk(2'd3, "R11");

    // R5 upper pin bits ignored, neighbours untouched
    command(0, 8'h0D, 4'd1);  read_chk(2'd0, "R5");
    command(0, 8'hF8, 4'd9);  read_chk(2'd0, "R5");

    // R6 input op, R7 output op, R8 level op
    command(1, 8'd0, 4'd5);   read_chk(2'd0, "R6");
    command(2, 8'd6, 4'd5);   read_chk(2'd0, "R7"); read_chk(2'd1, "R7");
    command(3, 8'd6, 4'd0);   read_chk(2'd0, "R8"); read_chk(2'd1, "R8");
    command(7, 8'd1, 4'd3);   read_all("R6");

    // R12 same-cycle bus write and command on the pull register
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0000_FFFF;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_pin = 8'd2; cmd_arg = 4'd0;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; cmd_valid = 1'b0;
    m_pull = 16'hFFCF;
    check_ports("R12");
    read_chk(2'd2, "R12");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 7) command(int'($urandom_range(0, 7)), 8'($urandom), 4'($urandom));
      else       bus_write(2'($urandom), $urandom);
      if (it % 25 == 24) begin
        set_pad(8'($urandom));
        read_all("R4/R5");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule